// File: doc/BRIEF.md
# Oversampling Baud Tick Generator

This block turns a fast reference clock into the 16x oversampling strobe that a UART needs. Both the transmit shifter and the receive sampler share that strobe. The output is a single-cycle enable pulse, not a derived clock. The reference first passes through a prescaler: a select input picks division by one or by four. A 16-bit divisor then sets the strobe period. Software loads the divisor one byte at a time through two byte-wide write strobes, and every byte write restarts the count so that the new rate starts from a clean phase.

The strobe rate is the reference frequency divided by the prescale factor and then by the divisor. The serial bit rate is one sixteenth of the strobe rate. With a 14.7456 MHz reference, divisor 1 at divide-by-one gives 921.6 kbit/s and divisor 2304 gives 400 bit/s. At divide-by-four, divisor 2 gives 115.2 kbit/s and divisor 384 gives 600 bit/s. A divisor of zero stops the strobe.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 0, the prescaler phase is 0 and `tick16` stays low until a nonzero divisor is written.
- R2: With a nonzero divisor D and a fixed prescale factor P, `tick16` pulses exactly once every P*D reference cycles. P is 1 when `prescale_sel` is 0 and 4 when it is 1.
- R3: `wr_lo` loads `wr_data` into divisor bits 7:0 and `wr_hi` loads it into bits 15:8. Each strobe leaves the other byte unchanged, and both may be written in the same cycle.
- R4: While the divisor is 0, `tick16` never goes high.
- R5: Any divisor byte write restarts the count. Take the clock edge that samples the write as cycle 0; the first pulse is then high during cycle P*D after that edge.
- R6: When the divisor is greater than 1 and no write is in progress, a pulse is never followed by another pulse in the next cycle.
- R7: The prescaler phase runs on every cycle from the last restart, whatever `prescale_sel` is. At divide-by-four, a prescaled step happens in each cycle whose phase is 3 mod 4, so changing the select input mid-run moves onto that phase.
- R8: At divide-by-four with divisor 1, `tick16` is high one cycle in every four. At divide-by-one with divisor 1, it is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale_sel | input | 1 | 0: divide by 1, 1: divide by 4 |
| wr_lo | input | 1 | Write strobe for divisor low byte |
| wr_hi | input | 1 | Write strobe for divisor high byte |
| wr_data | input | 8 | Byte written by either strobe |
| tick16 | output | 1 | One-cycle 16x oversampling enable |

## Verification
The bench builds the block with its defaults: a 16-bit divisor split into two 8-bit lanes and a prescale factor of 4. With these values, the table points at both ends of the divisor range are within reach, from divisor 1 up to 65535, under both prescaler settings. The 200 MHz bench clock fits the full 65535-cycle period at divide-by-one into the run. Running the prescaler at 4 brings out its phase behaviour: a select change mid-run, and the one-in-four pattern with divisor 1.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

   typedef enum logic {
      PRE_PASS = 1'b0,
      PRE_SLOW = 1'b1
   } pre_mode_e;

   function automatic int unsigned lanes_of(input int unsigned total_w,
                                            input int unsigned lane_w);
      return (total_w + lane_w - 1) / lane_w;
   endfunction

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [baud_tick_pkg::lanes_of(DIV_W, BYTE_W)-1:0] wr_stb,
   input  logic [BYTE_W-1:0]                     wr_data,
   output logic [DIV_W-1:0]                      div_o,
   output logic                                  restart_o
);
   localparam int unsigned LANES = baud_tick_pkg::lanes_of(DIV_W, BYTE_W);

   if (LANES * BYTE_W != DIV_W) begin : g_bad_width
      $error("DIV_W must be a whole number of BYTE_W lanes");
   end

   logic [BYTE_W-1:0] lane_q [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q[g] <= '0;
         end else if (wr_stb[g]) begin
            lane_q[g] <= wr_data;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         div_o[i*BYTE_W +: BYTE_W] = lane_q[i];
      end
   end

   assign restart_o = |wr_stb;

   assert_lo_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb[0] && wr_stb[LANES-1]) |=> $stable(div_o[BYTE_W-1:0]));

   assert_hi_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb[0] && !wr_stb[LANES-1]) |=> $stable(div_o[DIV_W-1:DIV_W-BYTE_W]));

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
   import baud_tick_pkg::*;
#(
   parameter int unsigned PRE_FACTOR = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pre_mode_e mode_i,
   input  logic      restart_i,
   output logic      step_o
);
   if (PRE_FACTOR < 1) begin : g_bad_factor
      $error("PRE_FACTOR must be at least 1");
   end

   if (PRE_FACTOR == 1) begin : g_bypass
      assign step_o = 1'b1;
   end else begin : g_divide
      localparam int unsigned PW = $clog2(PRE_FACTOR);
      localparam logic [PW-1:0] LAST = PW'(PRE_FACTOR - 1);

      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase_q <= '0;
         end else if (restart_i || phase_q == LAST) begin
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end

      assign step_o = (mode_i == PRE_PASS) || (phase_q == LAST);

      assert_slow_step_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (step_o && mode_i == PRE_SLOW && $stable(mode_i)) |=> (mode_i == PRE_PASS || !step_o));
   end

endmodule

// File: rtl/baud_div_count.sv
module baud_div_count #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             restart_i,
   input  logic             step_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             div_zero;
   logic             at_end;

   assign div_zero = (div_i == '0);
   assign at_end   = (cnt_q == div_i - 1'b1);
   assign tick_o   = !div_zero && step_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (!div_zero && step_i) begin
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

   assert_zero_div_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero |-> !tick_o);

   assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!div_zero && !$past(restart_i) && $stable(div_i)) |-> (cnt_q < div_i));

   assert_restart_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (!tick_o || div_i == DIV_W'(1)));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_tick_pkg::*;
#(
   parameter int unsigned DIV_W      = 16,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned PRE_FACTOR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prescale_sel,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              tick16
);
   localparam int unsigned LANES = lanes_of(DIV_W, BYTE_W);

   if (LANES != 2) begin : g_bad_lanes
      $error("divisor must split into exactly a low and a high lane");
   end

   logic [LANES-1:0] wr_stb;
   logic [DIV_W-1:0] div_val;
   logic             restart;
   logic             step;
   pre_mode_e        mode;

   assign wr_stb = {wr_hi, wr_lo};
   assign mode   = pre_mode_e'(prescale_sel);

   baud_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .div_o     (div_val),
      .restart_o (restart)
   );

   baud_prescale #(.PRE_FACTOR(PRE_FACTOR)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode),
      .restart_i (restart),
      .step_o    (step)
   );

   baud_div_count #(.DIV_W(DIV_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_i     (div_val),
      .restart_i (restart),
      .step_i    (step),
      .tick_o    (tick16)
   );

   assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick16 && div_val > DIV_W'(1) && !wr_lo && !wr_hi) |=> !tick16);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !tick16);

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prescale_sel = 1'b0;
   logic       wr_lo = 1'b0;
   logic       wr_hi = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tick16;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   bit model_on = 0;

   // behavioural reference state
   int m_div = 0;
   int m_phase = 0;
   int m_steps = 0;

   always #2.5 clk = ~clk;

   baud_tick_gen u_dut (
      .clk(clk), .rst_n(rst_n), .prescale_sel(prescale_sel),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .tick16(tick16)
   );

   function automatic bit model_step_now();
      return (prescale_sel == 1'b0) || (m_phase % 4 == 3);
   endfunction

   function automatic bit model_tick();
      return (m_div != 0) && model_step_now() && (m_steps == m_div - 1);
   endfunction

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R2 R7)
   always @(negedge clk) begin
      if (model_on && !done) check("R2 R7 cycle model", tick16, model_tick());
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; m_phase = 0; m_steps = 0;
      end else if (wr_lo || wr_hi) begin
         if (wr_lo) m_div = (m_div & 32'hFF00) | wr_data;
         if (wr_hi) m_div = (m_div & 32'h00FF) | (int'(wr_data) << 8);
         m_phase = 0; m_steps = 0;
      end else begin
         if (m_div != 0 && model_step_now())
            m_steps = (m_steps == m_div - 1) ? 0 : m_steps + 1;
         m_phase = (m_phase + 1) % 4;
      end
   end

   task automatic write_bytes(input bit lo, input bit hi, input int value);
      @(posedge clk); #1;
      wr_lo = lo; wr_hi = hi;
      wr_data = lo ? value[7:0] : value[15:8];
      if (lo && hi) wr_data = value[7:0];
      @(posedge clk); #1;
      wr_lo = 0; wr_hi = 0;
   endtask

   task automatic write_both(input int value);
      // same-cycle write: low lane takes wr_data, high lane too, so write twice
      write_bytes(1, 0, value);
      write_bytes(0, 1, value);
   endtask

   task automatic latency(input int limit, output int n);
      n = 0;
      for (int i = 1; i <= limit; i++) begin
         @(negedge clk);
         if (tick16) begin n = i; return; end
      end
   endtask

   task automatic count_ticks(input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (tick16) n++;
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int n;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      model_on = 1;
      // R1: reset state, no tick
      count_ticks(50, n);
      check("R1 reset quiet", n, 0);

      // R8: divisor 1 at divide-by-one, tick every cycle
      write_both(1);
      count_ticks(20, n);
      check("R8 div1 pass", n, 20);

      // R8: divisor 1 at divide-by-four, one in four
      prescale_sel = 1;
      write_both(1);
      latency(10, n);
      check("R5 div1 slow latency", n, 4);
      count_ticks(40, n);
      check("R8 div1 slow count", n, 10);

      // R2: divisor 2 at divide-by-four (115.2k point)
      write_both(2);
      latency(20, n);
      check("R5 div2 slow latency", n, 8);
      count_ticks(80, n);
      check("R2 div2 slow count", n, 10);

      // R3: bytes written separately form 0x0180 (600 bps point)
      write_bytes(1, 0, 16'h0080);
      write_bytes(0, 1, 16'h0100);
      latency(3000, n);
      check("R3 R5 div 0x0180 slow latency", n, 1536);
      count_ticks(1536 * 2, n);
      check("R2 div 0x0180 slow count", n, 2);

      // R3: low byte alone rewrites to 0x00, high byte kept -> 0x0100
      write_bytes(1, 0, 16'h0000);
      latency(2000, n);
      check("R3 high byte kept latency", n, 1024);

      // R2: 2304 at divide-by-one (400 bps point)
      prescale_sel = 0;
      write_both(2304);
      latency(5000, n);
      check("R5 div2304 latency", n, 2304);
      count_ticks(2304 * 2, n);
      check("R2 div2304 count", n, 2);

      // R5: rewrite mid-period restarts the count
      write_both(100);
      repeat (60) @(negedge clk);
      write_both(100);
      latency(300, n);
      check("R5 mid-period restart", n, 100);

      // R7: select change mid-run, model covers phase
      write_both(3);
      repeat (7) @(posedge clk);
      #1 prescale_sel = 1;
      count_ticks(60, n);
      prescale_sel = 0;
      check("R7 select change pulses", n > 0, 1);

      // R4: divisor zero gives nothing
      write_both(0);
      count_ticks(300, n);
      check("R4 zero divisor", n, 0);

      // R2: full-range divisor at divide-by-one
      write_both(65535);
      latency(70000, n);
      check("R2 R5 div 65535 latency", n, 65535);

      // R6: single-cycle pulses for divisor 5
      write_both(5);
      count_ticks(50, n);
      check("R6 div5 count", n, 10);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule